// File: doc/BRIEF.md
# Output-Buffered Cell Switch Element

This block is an eight-input, eight-output self-routing switch for fixed-length cells. A cell is 53 bytes long and travels as 27 consecutive 16-bit words. A start marker flags the first word. The top three bits of that first word are the destination tag, and they alone select the output port. No central scheduler is involved. Every output owns a buffer that holds 128 whole cells. A cell that arrives for a full buffer is thrown away in one piece. The inputs are never stalled.

Buffer space is claimed on the clock edge that takes a cell's first word, so the cells on one output always leave in the order they started. This holds even when a slower input finishes writing its cell after a faster one. When several inputs start cells for the same output on the same edge, they are queued by ascending input index. If the buffer cannot take them all, the lowest indices win. Each output counts the cells it holds and the cells it has dropped.

Each input runs a small state machine with three states. ING_IDLE moves to ING_STORE when a start word is granted space, or to ING_DISCARD when it is refused. Either of those states returns to ING_IDLE on the 27th valid word. Each output runs a reader with two states. EGR_IDLE moves to EGR_SEND when the cell at the head of its queue is fully written. After the last word has been accepted, EGR_SEND either stays in EGR_SEND, if the next queued cell is already complete, or returns to EGR_IDLE. `BUF_CELLS` must be a power of two.

Top module: `cell_switch`

## Requirements
- R1: A cell goes to the output named by bits 15:13 of its first word. All words leave unchanged, including those tag bits, except for the padding described in R2.
- R2: Each output cell is 27 words long. `out_soc` is high on the first word only. The low byte (bits 7:0) of the 27th word is driven as zero.
- R3: Cells that start on the same edge for the same output leave in ascending input-index order.
- R4: On one output, cells leave in the order of their first words, even when a cell that started later has finished writing first.
- R5: An output holds at most 128 cells. A start is accepted only if the current count plus the starts accepted on that edge from lower-indexed inputs is below 128. Cells freed on the same edge are not counted. Otherwise the whole cell is dropped, so among simultaneous starts the lowest indices win.
- R6: `out_drops` rises by one for each discarded cell. A discarded cell leaves no trace on any output and does not disturb cells that were accepted.
- R7: `out_cells` rises on the edge that accepts a cell's first word and falls on the edge that transfers that cell's last word.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady. The words of one cell are never interleaved with the words of another.
- R9: Input words with `in_valid` low are skipped, so a cell may arrive with pauses. Valid words without a start marker outside a cell are ignored. A start marker inside a cell is treated as ordinary data.
- R10: After reset, all `out_valid` are low and all cell and drop counts are zero.
- R11: All outputs work at the same time, so a full permutation of eight cells is delivered in parallel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 8 | Per input: word present |
| in_soc | input | 8 | Per input: first word of a cell |
| in_data | input | 8x16 | Per input: data word |
| out_ready | input | 8 | Per output: the receiver takes a word |
| out_valid | output | 8 | Per output: word present |
| out_soc | output | 8 | Per output: first word of a cell |
| out_data | output | 8x16 | Per output: data word |
| out_cells | output | 8x8 | Per output: cells held in the buffer |
| out_drops | output | 8x16 | Per output: discarded cells, wraps around |

## Verification
Two things can happen on the same edge: space is granted to several simultaneous starts, and an output buffer reaches its limit. The bench provokes this by stalling one output and loading it with 124 cells. It then starts cells from all eight inputs to that output on one edge. The drop count must grow by exactly four. After the output is released, the drained sequence must hold inputs zero to three in index order and nothing from inputs four to seven. A further pair of cells, where the one that starts later finishes writing first, shows that the read order follows the order of the start edges.

// File: rtl/cell_switch_pkg.sv
package cell_switch_pkg;
    typedef enum logic [1:0] {
        ING_IDLE,
        ING_STORE,
        ING_DISCARD
    } ing_state_e;

    typedef enum logic {
        EGR_IDLE,
        EGR_SEND
    } egr_state_e;
endpackage

// File: rtl/cell_switch_ingress.sv
module cell_switch_ingress
    import cell_switch_pkg::*;
#(
    parameter int WW     = 16,
    parameter int CW     = 27,
    parameter int DST_W  = 3,
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_soc,
    input  logic [WW-1:0]     in_data,
    output logic              req_o,
    output logic [DST_W-1:0]  req_dst_o,
    input  logic              grant_i,
    input  logic [SLOT_W-1:0] grant_slot_i,
    output logic              wr_en_o,
    output logic [DST_W-1:0]  wr_dst_o,
    output logic [SLOT_W-1:0] wr_slot_o,
    output logic [$clog2(CW)-1:0] wr_idx_o,
    output logic [WW-1:0]     wr_data_o,
    output logic              wr_last_o
);
    localparam int IDX_W = $clog2(CW);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CW - 1);

    ing_state_e        state_q, state_d;
    logic [IDX_W-1:0]  cnt_q;
    logic [DST_W-1:0]  dst_q;
    logic [SLOT_W-1:0] slot_q;
    logic              start;
    logic              at_last;

    assign start   = (state_q == ING_IDLE) && in_valid && in_soc;
    assign at_last = in_valid && (cnt_q == LAST_IDX);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ING_IDLE:    if (start) state_d = grant_i ? ING_STORE : ING_DISCARD;
            ING_STORE:   if (at_last) state_d = ING_IDLE;
            ING_DISCARD: if (at_last) state_d = ING_IDLE;
            default:     state_d = ING_IDLE;
        endcase
    end

    // state register and per-cell context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ING_IDLE;
            cnt_q   <= '0;
            dst_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                cnt_q  <= IDX_W'(1);
                dst_q  <= req_dst_o;
                slot_q <= grant_slot_i;
            end else if (state_q != ING_IDLE && in_valid) begin
                cnt_q <= at_last ? '0 : cnt_q + IDX_W'(1);
            end
        end
    end

    // outputs: request and write port
    always_comb begin
        req_o     = start;
        req_dst_o = in_data[WW-1 -: DST_W];
        wr_data_o = in_data;
        if (state_q == ING_IDLE) begin
            wr_en_o   = start && grant_i;
            wr_dst_o  = req_dst_o;
            wr_slot_o = grant_slot_i;
            wr_idx_o  = '0;
            wr_last_o = 1'b0;
        end else begin
            wr_en_o   = (state_q == ING_STORE) && in_valid;
            wr_dst_o  = dst_q;
            wr_slot_o = slot_q;
            wr_idx_o  = cnt_q;
            wr_last_o = (state_q == ING_STORE) && at_last;
        end
    end

    AST_CELL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ING_IDLE && at_last) |=> (state_q == ING_IDLE)); // R2
endmodule

// File: rtl/cell_switch_alloc.sv
module cell_switch_alloc #(
    parameter int NP        = 8,
    parameter int BUF_CELLS = 128,
    parameter int DROP_W    = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NP-1:0]                          req_i,
    input  logic                                   release_i,
    output logic [NP-1:0]                          grant_o,
    output logic [NP-1:0][$clog2(BUF_CELLS)-1:0]   slot_o,
    output logic [$clog2(BUF_CELLS+1)-1:0]         cells_o,
    output logic [DROP_W-1:0]                      drops_o
);
    localparam int SLOT_W = $clog2(BUF_CELLS);
    localparam int CNT_W  = $clog2(BUF_CELLS + 1);
    localparam int ACC_W  = $clog2(NP + 1);

    logic [SLOT_W-1:0] tail_q;
    logic [CNT_W-1:0]  occ_q;
    logic [DROP_W-1:0] drops_q;
    logic [ACC_W-1:0]  n_grant, n_deny;

    // grants in ascending input order while space remains
    always_comb begin
        int taken;
        int denied;
        taken  = 0;
        denied = 0;
        for (int i = 0; i < NP; i++) begin
            grant_o[i] = 1'b0;
            slot_o[i]  = tail_q + SLOT_W'(taken);
            if (req_i[i]) begin
                if ((int'(occ_q) + taken) < BUF_CELLS) begin
                    grant_o[i] = 1'b1;
                    taken      = taken + 1;
                end else begin
                    denied = denied + 1;
                end
            end
        end
        n_grant = ACC_W'(taken);
        n_deny  = ACC_W'(denied);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_q  <= '0;
            occ_q   <= '0;
            drops_q <= '0;
        end else begin
            tail_q  <= tail_q + SLOT_W'(n_grant);
            occ_q   <= occ_q + CNT_W'(n_grant) - CNT_W'(release_i);
            drops_q <= drops_q + DROP_W'(n_deny);
        end
    end

    assign cells_o = occ_q;
    assign drops_o = drops_q;

    // helpers for the ordering check
    logic [NP-1:0] deny_v, low_deny, above_low;
    assign deny_v    = req_i & ~grant_o;
    assign low_deny  = deny_v & (~deny_v + NP'(1));
    assign above_low = ~((low_deny << 1) - NP'(1));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CNT_W'(BUF_CELLS)); // R5
    AST_GRANT_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        (deny_v != '0) |-> ((grant_o & above_low) == '0)); // R5
    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> $stable(drops_q)); // R6
endmodule

// File: rtl/cell_switch_egress.sv
module cell_switch_egress
    import cell_switch_pkg::*;
#(
    parameter int NP        = 8,
    parameter int WW        = 16,
    parameter int CW        = 27,
    parameter int BUF_CELLS = 128,
    parameter int PAD_W     = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NP-1:0]                        wr_sel_i,
    input  logic [NP-1:0][$clog2(BUF_CELLS)-1:0] wr_slot_i,
    input  logic [NP-1:0][$clog2(CW)-1:0]        wr_idx_i,
    input  logic [NP-1:0][WW-1:0]                wr_data_i,
    input  logic [NP-1:0]                        wr_last_i,
    input  logic                                 out_ready,
    output logic                                 out_valid,
    output logic                                 out_soc,
    output logic [WW-1:0]                        out_data,
    output logic                                 release_o
);
    localparam int SLOT_W = $clog2(BUF_CELLS);
    localparam int IDX_W  = $clog2(CW);
    localparam int DEPTH  = BUF_CELLS * CW;
    localparam int MEM_AW = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CW - 1);

    logic [WW-1:0]        mem [DEPTH];
    logic [BUF_CELLS-1:0] done_q;
    logic [SLOT_W-1:0]    head_q, head_nx;
    logic [IDX_W-1:0]     idx_q;
    egr_state_e           state_q, state_d;
    logic [MEM_AW-1:0]    rd_addr;
    logic                 last_beat;
    logic [WW-1:0]        rd_word;

    assign head_nx   = head_q + SLOT_W'(1);
    assign rd_addr   = MEM_AW'(head_q) * MEM_AW'(CW) + MEM_AW'(idx_q);
    assign last_beat = (state_q == EGR_SEND) && out_ready && (idx_q == LAST_IDX);
    assign release_o = last_beat;

    // cell storage: every input may write its own slot in the same cycle
    always_ff @(posedge clk) begin
        for (int i = 0; i < NP; i++) begin
            if (wr_sel_i[i]) begin
                mem[MEM_AW'(wr_slot_i[i]) * MEM_AW'(CW) + MEM_AW'(wr_idx_i[i])] <= wr_data_i[i];
            end
        end
    end

    // completion flags per slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            if (last_beat) done_q[head_q] <= 1'b0;
            for (int i = 0; i < NP; i++) begin
                if (wr_sel_i[i] && wr_last_i[i]) done_q[wr_slot_i[i]] <= 1'b1;
            end
        end
    end

    // reader next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EGR_IDLE: if (done_q[head_q]) state_d = EGR_SEND;
            EGR_SEND: if (last_beat && !done_q[head_nx]) state_d = EGR_IDLE;
            default:  state_d = EGR_IDLE;
        endcase
    end

    // reader state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EGR_IDLE;
            head_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (last_beat) begin
                head_q <= head_nx;
                idx_q  <= '0;
            end else if (state_q == EGR_SEND && out_ready) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // reader outputs
    always_comb begin
        rd_word   = mem[rd_addr];
        out_valid = (state_q == EGR_SEND);
        out_soc   = out_valid && (idx_q == '0);
        out_data  = rd_word;
        if (idx_q == LAST_IDX) out_data = {rd_word[WW-1:PAD_W], PAD_W'(0)};
    end

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
    AST_CELL_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_soc); // R2
    AST_SEND_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> done_q[head_q]); // R4
endmodule

// File: rtl/cell_switch.sv
module cell_switch #(
    parameter int NP        = 8,
    parameter int WW        = 16,
    parameter int CW        = 27,
    parameter int BUF_CELLS = 128,
    parameter int DROP_W    = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [NP-1:0]                            in_valid,
    input  logic [NP-1:0]                            in_soc,
    input  logic [NP-1:0][WW-1:0]                    in_data,
    input  logic [NP-1:0]                            out_ready,
    output logic [NP-1:0]                            out_valid,
    output logic [NP-1:0]                            out_soc,
    output logic [NP-1:0][WW-1:0]                    out_data,
    output logic [NP-1:0][$clog2(BUF_CELLS+1)-1:0]   out_cells,
    output logic [NP-1:0][DROP_W-1:0]                out_drops
);
    localparam int DST_W  = $clog2(NP);
    localparam int SLOT_W = $clog2(BUF_CELLS);
    localparam int IDX_W  = $clog2(CW);

    logic [NP-1:0]                   req;
    logic [NP-1:0][DST_W-1:0]        req_dst;
    logic [NP-1:0]                   grant;
    logic [NP-1:0][SLOT_W-1:0]       grant_slot;
    logic [NP-1:0]                   wr_en;
    logic [NP-1:0][DST_W-1:0]        wr_dst;
    logic [NP-1:0][SLOT_W-1:0]       wr_slot;
    logic [NP-1:0][IDX_W-1:0]        wr_idx;
    logic [NP-1:0][WW-1:0]           wr_data;
    logic [NP-1:0]                   wr_last;

    // per output: grants and slots seen by every input
    logic [NP-1:0][NP-1:0]              gnt_m;
    logic [NP-1:0][NP-1:0][SLOT_W-1:0]  slot_m;
    logic [NP-1:0]                      release_v;

    // steer each input's grant back from its target output
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            grant[i]      = gnt_m[req_dst[i]][i];
            grant_slot[i] = slot_m[req_dst[i]][i];
        end
    end

    for (genvar gi = 0; gi < NP; gi++) begin : g_in
        cell_switch_ingress #(
            .WW(WW), .CW(CW), .DST_W(DST_W), .SLOT_W(SLOT_W)
        ) ingress_i (
            .clk(clk), .rst_n(rst_n),
            .in_valid(in_valid[gi]), .in_soc(in_soc[gi]), .in_data(in_data[gi]),
            .req_o(req[gi]), .req_dst_o(req_dst[gi]),
            .grant_i(grant[gi]), .grant_slot_i(grant_slot[gi]),
            .wr_en_o(wr_en[gi]), .wr_dst_o(wr_dst[gi]), .wr_slot_o(wr_slot[gi]),
            .wr_idx_o(wr_idx[gi]), .wr_data_o(wr_data[gi]), .wr_last_o(wr_last[gi])
        );
    end

    for (genvar go = 0; go < NP; go++) begin : g_out
        logic [NP-1:0] req_here;
        logic [NP-1:0] wr_here;

        always_comb begin
            for (int i = 0; i < NP; i++) begin
                req_here[i] = req[i] && (req_dst[i] == DST_W'(go));
                wr_here[i]  = wr_en[i] && (wr_dst[i] == DST_W'(go));
            end
        end

        cell_switch_alloc #(
            .NP(NP), .BUF_CELLS(BUF_CELLS), .DROP_W(DROP_W)
        ) alloc_i (
            .clk(clk), .rst_n(rst_n),
            .req_i(req_here), .release_i(release_v[go]),
            .grant_o(gnt_m[go]), .slot_o(slot_m[go]),
            .cells_o(out_cells[go]), .drops_o(out_drops[go])
        );

        cell_switch_egress #(
            .NP(NP), .WW(WW), .CW(CW), .BUF_CELLS(BUF_CELLS), .PAD_W(8)
        ) egress_i (
            .clk(clk), .rst_n(rst_n),
            .wr_sel_i(wr_here), .wr_slot_i(wr_slot), .wr_idx_i(wr_idx),
            .wr_data_i(wr_data), .wr_last_i(wr_last),
            .out_ready(out_ready[go]),
            .out_valid(out_valid[go]), .out_soc(out_soc[go]), .out_data(out_data[go]),
            .release_o(release_v[go])
        );

        AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[go] && out_soc[go]) |-> (out_data[go][WW-1 -: DST_W] == DST_W'(go))); // R1
    end
endmodule

// File: tb/cell_switch_tb.sv
module cell_switch_tb_top;
    localparam int NP = 8;
    localparam int CW = 27;
    localparam int CAP = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] v = '0, s = '0, rdy = '1;
    logic [NP-1:0][15:0] d = '0;
    logic [NP-1:0] ov, osoc;
    logic [NP-1:0][15:0] od;
    logic [NP-1:0][7:0] cells;
    logic [NP-1:0][15:0] drops;

    always #5 clk = ~clk;

    cell_switch dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v), .in_soc(s), .in_data(d),
        .out_ready(rdy), .out_valid(ov), .out_soc(osoc), .out_data(od),
        .out_cells(cells), .out_drops(drops)
    );

    int checks = 0, errors = 0;
    int exp_id [NP][512];
    int pushed [NP], popped [NP], drops_exp [NP], widx [NP];
    bit bad [NP], prev_stall [NP];
    logic [15:0] prev_data [NP];
    int next_id = 1;

    function automatic logic [15:0] cell_word(int dst, int id, int k);
        if (k == 0) return {3'(dst), 13'(id)};
        return {8'(id * 7 + k), 8'(k * 13 + id)};
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // bench model of acceptance (R5, R6)
    task automatic predict(int dst, int id);
        if (pushed[dst] - popped[dst] < CAP) begin
            exp_id[dst][pushed[dst]] = id;
            pushed[dst]++;
        end else begin
            drops_exp[dst]++;
        end
    endtask

    task automatic send_cell(int i, int dst, int id, bit gaps, bit soc_mid);
        @(posedge clk); #1;
        v[i] = 1'b1; s[i] = 1'b1; d[i] = cell_word(dst, id, 0);
        for (int k = 1; k < CW; k++) begin
            @(posedge clk); #1;
            s[i] = soc_mid && (k == 5);
            if (gaps && (k % 4 == 0)) begin
                v[i] = 1'b0;
                @(posedge clk); #1;
            end
            v[i] = 1'b1;
            d[i] = cell_word(dst, id, k);
        end
        @(posedge clk); #1;
        v[i] = 1'b0; s[i] = 1'b0;
    endtask

    // output monitor: content, order, padding and hold behaviour
    always @(negedge clk) begin
        if (rst_n) begin
            for (int o = 0; o < NP; o++) begin
                if (prev_stall[o])
                    check(ov[o] && od[o] == prev_data[o], "R8", "held word", od[o], prev_data[o]);
                if (ov[o] && rdy[o]) begin
                    automatic int k = widx[o];
                    automatic logic [15:0] ew;
                    if (popped[o] >= pushed[o]) begin
                        if (k == 0) check(1'b0, "R6", "unexpected cell on output", o, -1);
                    end else begin
                        ew = cell_word(o, exp_id[o][popped[o]], k);
                        if (k == CW - 1) ew[7:0] = 8'h00;
                        if (!bad[o] && (od[o] != ew || osoc[o] != (k == 0))) begin
                            bad[o] = 1'b1;
                            $display("FAIL R1/R2/R4 out %0d word %0d actual=%h soc=%0d expected=%h soc=%0d",
                                     o, k, od[o], osoc[o], ew, (k == 0));
                        end
                    end
                    if (k == CW - 1) begin
                        checks++;
                        if (bad[o]) errors++;
                        bad[o] = 1'b0;
                        popped[o]++;
                        widx[o] = 0;
                    end else begin
                        widx[o] = k + 1;
                    end
                end
                prev_stall[o] = ov[o] && !rdy[o];
                prev_data[o]  = od[o];
            end
        end
    end

    function automatic bit busy();
        for (int o = 0; o < NP; o++) if (popped[o] != pushed[o]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic wait_drain(string tag);
        int t = 0;
        while (busy() && t < 6000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        for (int o = 0; o < NP; o++) begin
            check(popped[o] == pushed[o], tag, "cells delivered", popped[o], pushed[o]);
            check(cells[o] == 0, "R7", "count after drain", cells[o], 0);
            check(drops[o] == 16'(drops_exp[o]), "R6", "drop count", drops[o], drops_exp[o]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int o = 0; o < NP; o++) begin
            check(ov[o] == 1'b0, "R10", "out_valid after reset", ov[o], 0);
            check(cells[o] == 0, "R10", "cells after reset", cells[o], 0);
            check(drops[o] == 0, "R10", "drops after reset", drops[o], 0);
        end
    endtask

    task automatic t_single();
        int id = next_id++;
        predict(5, id);
        send_cell(0, 5, id, 0, 0);
        wait_drain("R1");
    endtask

    task automatic t_all_to_one();
        for (int i = 0; i < NP; i++) predict(3, next_id + i);
        for (int i = 0; i < NP; i++) begin
            automatic int ii = i;
            automatic int id = next_id + i;
            fork send_cell(ii, 3, id, 0, 0); join_none
        end
        next_id += NP;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(cells[3] == 8, "R7", "count after simultaneous starts", cells[3], 8);
        wait fork;
        wait_drain("R3");
    endtask

    task automatic t_permute();
        for (int i = 0; i < NP; i++) predict((3 * i + 1) % NP, next_id + i);
        for (int i = 0; i < NP; i++) begin
            automatic int ii = i;
            automatic int id = next_id + i;
            fork send_cell(ii, (3 * ii + 1) % NP, id, 0, 0); join_none
        end
        next_id += NP;
        wait fork;
        wait_drain("R11");
    endtask

    task automatic t_backpressure();
        for (int i = 0; i < 3; i++) predict(6, next_id + i);
        fork
            for (int c = 0; c < 220; c++) begin
                @(posedge clk); #1;
                rdy[6] = (c % 3) != 1 && (c % 7) != 2;
            end
        join_none
        for (int i = 0; i < 3; i++) begin
            automatic int ii = i;
            automatic int id = next_id + i;
            fork send_cell(ii, 6, id, 0, 0); join_none
        end
        next_id += 3;
        wait fork;
        rdy[6] = 1'b1;
        wait_drain("R8");
    endtask

    task automatic t_gaps();
        int a = next_id++;
        int b = next_id++;
        predict(4, a);
        fork send_cell(1, 4, a, 1, 0); join_none
        repeat (3) @(posedge clk);
        predict(4, b);
        fork send_cell(2, 4, b, 0, 0); join_none
        wait fork;
        wait_drain("R4");
    endtask

    task automatic t_junk();
        int id;
        @(posedge clk); #1;
        v[3] = 1'b1; s[3] = 1'b0;
        for (int k = 0; k < 10; k++) begin
            d[3] = cell_word(0, 77, k);
            @(posedge clk); #1;
        end
        v[3] = 1'b0;
        repeat (40) @(negedge clk);
        check(cells[0] == 0, "R9", "words without start ignored", cells[0], 0);
        check(ov[0] == 1'b0, "R9", "no output from stray words", ov[0], 0);
        id = next_id++;
        predict(7, id);
        send_cell(3, 7, id, 0, 1);
        wait_drain("R9");
    endtask

    task automatic t_overflow();
        rdy[2] = 1'b0;
        for (int r = 0; r < 15; r++) begin
            for (int i = 0; i < NP; i++) predict(2, next_id + i);
            for (int i = 0; i < NP; i++) begin
                automatic int ii = i;
                automatic int id = next_id + i;
                fork send_cell(ii, 2, id, 0, 0); join_none
            end
            next_id += NP;
            wait fork;
        end
        for (int i = 0; i < 4; i++) predict(2, next_id + i);
        for (int i = 0; i < 4; i++) begin
            automatic int ii = i;
            automatic int id = next_id + i;
            fork send_cell(ii, 2, id, 0, 0); join_none
        end
        next_id += 4;
        wait fork;
        @(negedge clk);
        check(cells[2] == 124, "R7", "count before contested round", cells[2], 124);
        // eight simultaneous starts with four free slots
        for (int i = 0; i < NP; i++) predict(2, next_id + i);
        for (int i = 0; i < NP; i++) begin
            automatic int ii = i;
            automatic int id = next_id + i;
            fork send_cell(ii, 2, id, 0, 0); join_none
        end
        next_id += NP;
        wait fork;
        @(negedge clk);
        check(cells[2] == CAP, "R5", "buffer full", cells[2], CAP);
        check(drops[2] == 4, "R6", "drops in contested round", drops[2], 4);
        predict(2, next_id);
        send_cell(5, 2, next_id, 0, 0);
        next_id++;
        @(negedge clk);
        check(drops[2] == 5, "R5", "cell to full buffer dropped", drops[2], 5);
        check(cells[2] == CAP, "R5", "count unchanged by drop", cells[2], CAP);
        check(ov[2] == 1'b1 && osoc[2] == 1'b1, "R8", "stalled output holds first word", ov[2], 1);
        rdy[2] = 1'b1;
        wait_drain("R5");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int o = 0; o < NP; o++) begin
            pushed[o] = 0; popped[o] = 0; drops_exp[o] = 0; widx[o] = 0;
            bad[o] = 1'b0; prev_stall[o] = 1'b0; prev_data[o] = '0;
        end
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_single();
        t_all_to_one();
        t_permute();
        t_backpressure();
        t_gaps();
        t_junk();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule